// File: doc/BRIEF.md
# BPSK Baseband Sample Source

This block feeds a DAC transmit path with 16-bit signed I and Q baseband samples so that the upconverted carrier is binary phase-shift keyed. Each data bit becomes one of two antipodal I codes close to full scale. Q never leaves zero, so the modulated carrier keeps a constant envelope and only its phase flips.

The DAC interface pulls samples rather than having them pushed. The I and Q channels each have a request strobe. A channel register changes only in the cycle after its strobe is high. Bits come from one of two places. The first is a 32-bit pattern, captured while reset is held and replayed in a loop without end. The second is an external bit port with a ready/valid handshake. Each bit lasts a set number of accepted I requests. The block runs directly on the DAC interface clock.

Top module: `bpsk_iq_source`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers are cleared: `i_out` and `q_out` read 0, `underflow` reads 0, and `ext_ready` is 0 while no request is present.
- R2: In the cycle after a clock edge with `req_i` high, `i_out` carries the level of the current bit. Bit value 0 gives 16'h7FF0 and bit value 1 gives 16'h8010.
- R3: In the cycle after a clock edge with `req_q` high, `q_out` reads 16'h0000.
- R4: `i_out` keeps its value across every clock edge where `req_i` is low.
- R5: Each bit covers `sps` consecutive accepted I requests. A value of 0 on `sps` counts as 1. The first accepted I request after reset starts a symbol.
- R6: With `src_sel` = 0, the pattern on `pattern` is captured at each clock edge while `rst_n` is low. Later changes on that port have no effect. Bits are sent from bit 31 down to bit 0, and then bit 31 follows again.
- R7: `ext_ready` is high exactly when `src_sel` = 1, `req_i` = 1 and that request starts a symbol. When `ext_valid` is also high, `ext_bit` becomes the bit of that symbol.
- R8: If `ext_valid` is low when an external-source symbol starts, the previous bit is repeated (0 if none since reset). `underflow` then goes to 1 and stays there until reset.
- R9: With `src_sel` = 0, `ext_ready` stays 0, and `ext_bit` and `ext_valid` do not affect `i_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DAC interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | Bit source: 0 pattern, 1 external port |
| pattern | input | 32 | Pattern value, captured while reset is low |
| sps | input | 8 | Samples per symbol (0 treated as 1) |
| ext_bit | input | 1 | External data bit |
| ext_valid | input | 1 | External bit is offered |
| ext_ready | output | 1 | Block takes the external bit this cycle |
| req_i | input | 1 | DAC request for the next I sample |
| req_q | input | 1 | DAC request for the next Q sample |
| i_out | output | 16 | Signed I sample |
| q_out | output | 16 | Signed Q sample |
| underflow | output | 1 | Sticky: external bit missing at a symbol start |

## Verification
The assertions expect `src_sel` and `sps` to stay still for the length of a symbol, because a change in the middle would blur where a symbol starts. The stimulus therefore changes them only between tests and always resets after changing them. The external handshake assumes the offered bit holds through the request cycle. The bench keeps `ext_bit` and `ext_valid` fixed around each request and changes them only at falling edges. Idle cycles are placed between requests so that the hold behaviour is checked as well as the request behaviour.

// File: rtl/bpsk_pkg.sv
// Package: shared constants and helpers for the BPSK sample source.
// Assumes 16-bit two's-complement DAC samples.
package bpsk_pkg;
    localparam int SAMPLE_W = 16;
    localparam logic [SAMPLE_W-1:0] LEVEL_POS = 16'h7FF0;
    localparam logic [SAMPLE_W-1:0] LEVEL_NEG = 16'h8010;
    localparam logic [SAMPLE_W-1:0] LEVEL_ZERO = '0;

    typedef enum logic {SRC_PATTERN = 1'b0, SRC_EXTERNAL = 1'b1} bit_src_e;

    // Map a data bit to its antipodal I level.
    function automatic logic [SAMPLE_W-1:0] bit_to_level(input logic b);
        return b ? LEVEL_NEG : LEVEL_POS;
    endfunction
endpackage

// File: rtl/bpsk_symbol_timer.sv
// Module: bpsk_symbol_timer
// Counts accepted I requests inside a symbol and flags the request that
// starts a new symbol. Assumes sps holds still during a symbol; 0 acts as 1.
module bpsk_symbol_timer #(
    parameter int SPS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [SPS_W-1:0] sps,
    output logic             sym_start
);
    logic [SPS_W-1:0] cnt;
    logic [SPS_W-1:0] last_idx;
    logic             at_end;

    // Index of the final sample within a symbol.
    always_comb begin
        last_idx = (sps == '0) ? '0 : sps - 1'b1;
        at_end   = (cnt >= last_idx);
    end

    // A request that finds the counter at zero opens a symbol.
    assign sym_start = req_i && (cnt == '0);

    // Advance the sample counter on each accepted I request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (req_i) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

    // R4/R5: the counter moves only on I requests
    a_r5_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(cnt));
endmodule

// File: rtl/bpsk_bit_source.sv
// Module: bpsk_bit_source
// Supplies the data bit for each sample. In pattern mode it walks a captured
// pattern from the top bit down and wraps. In external mode it takes a bit by
// handshake at each symbol start, repeating the last bit and flagging a
// sticky underflow if none is offered. Assumes src_sel only changes between symbols.
module bpsk_bit_source #(
    parameter int PAT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic [PAT_W-1:0] pattern,
    input  logic             take,
    input  logic             ext_bit,
    input  logic             ext_valid,
    output logic             ext_ready,
    output logic             bit_now,
    output logic             underflow
);
    import bpsk_pkg::*;

    localparam int PTR_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(PAT_W - 1);

    logic [PAT_W-1:0] pat_reg;
    logic [PTR_W-1:0] ptr;
    logic             last_bit;
    logic             new_bit;
    bit_src_e         src;

    assign src = bit_src_e'(src_sel);

    // Select the bit a symbol start would use.
    always_comb begin
        if (src == SRC_EXTERNAL)
            new_bit = ext_valid ? ext_bit : last_bit;
        else
            new_bit = pat_reg[ptr];
    end

    // Handshake happens only at an external-mode symbol start.
    assign ext_ready = (src == SRC_EXTERNAL) && take;
    // Bit for the current sample: fresh at a symbol start, held otherwise.
    assign bit_now   = take ? new_bit : last_bit;

    // Capture the pattern while in reset; otherwise walk the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_reg <= pattern;
            ptr     <= PTR_TOP;
        end else if (take && src == SRC_PATTERN) begin
            ptr <= (ptr == '0) ? PTR_TOP : ptr - 1'b1;
        end
    end

    // Remember the bit of the running symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_bit <= 1'b0;
        else if (take)
            last_bit <= new_bit;
    end

    // Sticky flag for a missing external bit at a symbol start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            underflow <= 1'b0;
        else if (take && src == SRC_EXTERNAL && !ext_valid)
            underflow <= 1'b1;
    end

    // R8: once raised, underflow stays up until reset
    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    // R9: no handshake while the pattern is the source
    a_r9_ready_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ready |-> src_sel);
endmodule

// File: rtl/bpsk_iq_mapper.sv
// Module: bpsk_iq_mapper
// Registers the I and Q samples. I takes the level of the current bit on an
// I request; Q is refreshed with zero on a Q request. Both hold otherwise.
module bpsk_iq_mapper (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_i,
    input  logic                           req_q,
    input  logic                           bit_now,
    output logic [bpsk_pkg::SAMPLE_W-1:0]  i_out,
    output logic [bpsk_pkg::SAMPLE_W-1:0]  q_out
);
    import bpsk_pkg::*;

    // Update the I sample on its request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            i_out <= LEVEL_ZERO;
        else if (req_i)
            i_out <= bit_to_level(bit_now);
    end

    // Update the Q sample on its request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_out <= LEVEL_ZERO;
        else if (req_q)
            q_out <= LEVEL_ZERO;
    end

    // R2: a served I request always leaves a legal level
    a_r2_i_level: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (i_out == LEVEL_POS || i_out == LEVEL_NEG));
    // R4: I holds without a request
    a_r4_i_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(i_out));
endmodule

// File: rtl/bpsk_iq_source.sv
// Module: bpsk_iq_source (top)
// BPSK baseband sample source clocked by the DAC interface clock. Samples are
// pulled by per-channel request strobes; bits come from a looping pattern or an
// external handshake port and each lasts sps accepted I requests.
module bpsk_iq_source #(
    parameter int PAT_W = 32,
    parameter int SPS_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          src_sel,
    input  logic [PAT_W-1:0]              pattern,
    input  logic [SPS_W-1:0]              sps,
    input  logic                          ext_bit,
    input  logic                          ext_valid,
    output logic                          ext_ready,
    input  logic                          req_i,
    input  logic                          req_q,
    output logic [bpsk_pkg::SAMPLE_W-1:0] i_out,
    output logic [bpsk_pkg::SAMPLE_W-1:0] q_out,
    output logic                          underflow
);
    logic sym_start;
    logic bit_now;

    bpsk_symbol_timer #(.SPS_W(SPS_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .sps       (sps),
        .sym_start (sym_start)
    );

    bpsk_bit_source #(.PAT_W(PAT_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .pattern   (pattern),
        .take      (sym_start),
        .ext_bit   (ext_bit),
        .ext_valid (ext_valid),
        .ext_ready (ext_ready),
        .bit_now   (bit_now),
        .underflow (underflow)
    );

    bpsk_iq_mapper u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .req_q   (req_q),
        .bit_now (bit_now),
        .i_out   (i_out),
        .q_out   (q_out)
    );

    // R7: a handshake only ever coincides with an I request
    a_r7_ready_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ready |-> req_i);
    // R3: a served Q request leaves zero on Q
    a_r3_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> (q_out == '0));
endmodule

// File: tb/sim_bpsk_iq_source.sv
// Directed bench for bpsk_iq_source: one task per scenario.
module sim_bpsk_iq_source;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_sel = 1'b0;
    logic [31:0] pattern = '0;
    logic [7:0]  sps = 8'd1;
    logic        ext_bit = 1'b0;
    logic        ext_valid = 1'b0;
    logic        ext_ready;
    logic        req_i = 1'b0;
    logic        req_q = 1'b0;
    logic [15:0] i_out;
    logic [15:0] q_out;
    logic        underflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bpsk_iq_source u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pattern(pattern),
        .sps(sps), .ext_bit(ext_bit), .ext_valid(ext_valid),
        .ext_ready(ext_ready), .req_i(req_i), .req_q(req_q),
        .i_out(i_out), .q_out(q_out), .underflow(underflow)
    );

    function automatic logic [15:0] lvl(input logic b);
        return b ? 16'h8010 : 16'h7FF0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Hold reset for a few edges with the given pattern on the port.
    task automatic do_reset(input logic [31:0] pat);
        @(negedge clk);
        rst_n = 1'b0; req_i = 1'b0; req_q = 1'b0; pattern = pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle with the given strobes; returns ext_ready seen before the edge.
    task automatic cyc(input logic ri, input logic rq, output logic rdy);
        req_i = ri; req_q = rq;
        #1 rdy = ext_ready;
        @(negedge clk);
        req_i = 1'b0; req_q = 1'b0;
    endtask

    task automatic t_reset();
        logic rdy;
        src_sel = 1'b0; sps = 8'd1;
        do_reset(32'h1234_5678);
        check("R1 i_out", {16'h0, i_out}, 32'h0);
        check("R1 q_out", {16'h0, q_out}, 32'h0);
        check("R1 underflow", {31'h0, underflow}, 32'h0);
        cyc(1'b0, 1'b0, rdy);
        check("R1 ext_ready", {31'h0, rdy}, 32'h0);
    endtask

    // R2 R6 R9: pattern walk MSB first with wrap; external port ignored.
    task automatic t_pattern();
        logic rdy;
        logic [31:0] pat = 32'hA5C3_0F1E;
        src_sel = 1'b0; sps = 8'd1;
        do_reset(pat);
        pattern = 32'hFFFF_FFFF;
        for (int k = 0; k < 40; k++) begin
            ext_valid = k[0]; ext_bit = ~k[1];
            cyc(1'b1, 1'b0, rdy);
            check("R6 R2 pattern bit", {16'h0, i_out}, {16'h0, lvl(pat[31 - (k % 32)])});
            check("R9 ext_ready low", {31'h0, rdy}, 32'h0);
        end
        ext_valid = 1'b0;
    endtask

    // R5 R4: bits span sps requests; idle cycles hold I.
    task automatic t_sps();
        logic rdy;
        logic [31:0] pat = 32'h6000_0000;
        logic [15:0] prev;
        src_sel = 1'b0; sps = 8'd3;
        do_reset(pat);
        for (int k = 0; k < 12; k++) begin
            cyc(1'b1, 1'b0, rdy);
            check("R5 symbol length", {16'h0, i_out}, {16'h0, lvl(pat[31 - (k / 3)])});
            prev = i_out;
            cyc(1'b0, 1'b0, rdy);
            check("R4 hold", {16'h0, i_out}, {16'h0, prev});
        end
        sps = 8'd0;
        do_reset(32'h5555_5555);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, 1'b0, rdy);
            check("R5 sps zero", {16'h0, i_out}, {16'h0, lvl(k[0])});
        end
    endtask

    // R3: Q stays zero while both channels are served.
    task automatic t_q();
        logic rdy;
        src_sel = 1'b0; sps = 8'd1;
        do_reset(32'hFFFF_0000);
        for (int k = 0; k < 4; k++) begin
            cyc(1'b1, 1'b1, rdy);
            check("R3 q zero", {16'h0, q_out}, 32'h0);
            check("R2 i with q", {16'h0, i_out}, {16'h0, lvl(1'b1)});
        end
    endtask

    // R7 R8: external handshake, underflow repeat and stickiness.
    task automatic t_ext();
        logic rdy;
        logic [7:0] bits = 8'b1011_0010;
        src_sel = 1'b1; sps = 8'd2;
        do_reset(32'h0);
        for (int s = 0; s < 8; s++) begin
            ext_valid = 1'b1; ext_bit = bits[s];
            cyc(1'b1, 1'b0, rdy);
            check("R7 ready at start", {31'h0, rdy}, 32'h1);
            check("R7 ext bit", {16'h0, i_out}, {16'h0, lvl(bits[s])});
            ext_bit = ~bits[s];
            cyc(1'b1, 1'b0, rdy);
            check("R7 ready mid symbol", {31'h0, rdy}, 32'h0);
            check("R7 bit held", {16'h0, i_out}, {16'h0, lvl(bits[s])});
        end
        check("R8 no underflow yet", {31'h0, underflow}, 32'h0);
        ext_valid = 1'b0; ext_bit = 1'b0;
        cyc(1'b1, 1'b0, rdy);
        check("R8 repeat last", {16'h0, i_out}, {16'h0, lvl(bits[7])});
        check("R8 underflow set", {31'h0, underflow}, 32'h1);
        cyc(1'b1, 1'b0, rdy);
        ext_valid = 1'b1; ext_bit = 1'b0;
        cyc(1'b1, 1'b0, rdy);
        check("R7 after underflow", {16'h0, i_out}, {16'h0, lvl(1'b0)});
        check("R8 sticky", {31'h0, underflow}, 32'h1);
        do_reset(32'h0);
        check("R1 underflow cleared", {31'h0, underflow}, 32'h0);
        ext_valid = 1'b0;
        cyc(1'b1, 1'b0, rdy);
        check("R8 default bit zero", {16'h0, i_out}, {16'h0, lvl(1'b0)});
        ext_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_pattern();
        t_sps();
        t_q();
        t_ext();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule